// File: doc/BRIEF.md
# Transfer-Controller Activation Enable Bank

This block decides, for each interrupt source, whether a service request starts the data-transfer controller or goes to the CPU as an ordinary interrupt. It holds one enable bit per source, packed into seven 8-bit registers that software reads and writes by register index. It also holds a 16-bit block-transfer counter that software loads.

When a source whose bit is set raises a request while the block is idle, the block pulses a start to the transfer engine and records which source it is serving. When the engine reports a finished transfer, the counter steps down by one. The served source's enable bit is then cleared by hardware if the engine's disable-select flag is set or if the counter has run out. A count of zero stands for 65536 transfers. Whenever a bit is cleared this way, the block emits a one-cycle end interrupt naming the served source.

Top module: `dtc_act_top`

## Requirements
- R1: After reset, and in the cycle after `standby` is high, all seven enable registers read 0.
- R2: Register i (0..6), bit b, enables source 8*i+b. A write with `wr_en` stores `wr_data` into the register named by `wr_sel`. `rd_data` shows the register named by `rd_sel` in the same cycle, and reads 0 when `rd_sel` is 7.
- R3: A request (`req_valid`, `req_src`) from an enabled source while `busy` is 0 raises `act_start` for exactly one cycle after the next clock edge. In that cycle `act_src` equals the source and `busy` is 1.
- R4: A request from a source whose enable bit is 0 drives `cpu_req` high with `cpu_req_src` equal to the source in the same cycle, and produces no `act_start`.
- R5: While `busy` is 1, requests start nothing and `act_src` keeps the served source.
- R6: Each `xfer_done` while busy decrements `cnt_q` by one modulo 65536, so a count of 0 becomes 65535. `xfer_done` while idle leaves `cnt_q` unchanged. Each `xfer_done` while busy also ends the transfer and clears `busy`.
- R7: If `dis_sel` is 1 when a transfer ends, the served source's enable bit reads 0 afterwards.
- R8: If `cnt_q` is 1 when a transfer ends, the served source's enable bit reads 0 afterwards.
- R9: If `dis_sel` is 0 and `cnt_q` is not 1 when a transfer ends, the served source's enable bit stays 1.
- R10: A hardware clear raises `end_irq` for exactly one cycle after the edge, with `end_src` set to the served source. A transfer end that clears nothing leaves `end_irq` at 0.
- R11: When a hardware clear and a software write hit the same register in one cycle, the cleared bit reads 0 and the other bits take the written value.
- R12: `cnt_ld` loads `cnt_ld_val` into `cnt_q` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Hardware standby; clears all enable bits |
| wr_en | input | 1 | Enable-register write strobe |
| wr_sel | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register index for the read |
| rd_data | output | 8 | Read data |
| cnt_ld | input | 1 | Counter load strobe |
| cnt_ld_val | input | 16 | Counter load value |
| cnt_q | output | 16 | Current transfer count |
| req_valid | input | 1 | Service request present |
| req_src | input | 6 | Requesting source index |
| act_start | output | 1 | One-cycle start to the transfer engine |
| act_src | output | 6 | Source being served |
| busy | output | 1 | Transfer in progress |
| xfer_done | input | 1 | Engine reports one transfer finished |
| dis_sel | input | 1 | Disable-select flag of the finished transfer |
| cpu_req | output | 1 | Request passed to the CPU (source not enabled) |
| cpu_req_src | output | 6 | Source of the passed request |
| end_irq | output | 1 | One-cycle CPU interrupt after a hardware clear |
| end_src | output | 6 | Source that was cleared |

## Verification
The bench loads a count of 0 and checks that it wraps to 65535 without clearing the bit. A design that compared against zero before decrementing would clear the bit early. A loaded count of 1 must clear the bit, and a design off by one would keep it. In the bench, a software write lands on the register being cleared in the same cycle. A design that lets the write win would leave the served bit set, and one that drops the write would lose the neighbouring bits. Requests made while busy, and transfer-done pulses while idle, must change nothing. Otherwise a second source would be started, or the counter would drift.

// File: rtl/dtc_act_pkg.sv
package dtc_act_pkg;
  typedef enum logic [0:0] {SEQ_IDLE, SEQ_BUSY} seq_st_e;
endpackage

// File: rtl/dtc_en_bank.sv
module dtc_en_bank #(
  parameter int NREG = 7,
  parameter int RW   = 8,
  localparam int NSRC = NREG * RW,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            standby,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [RW-1:0]   wr_data,
  input  logic [NSRC-1:0] hw_clr,
  input  logic [SELW-1:0] rd_sel,
  output logic [RW-1:0]   rd_data,
  output logic [NSRC-1:0] en_flat
);
  logic [RW-1:0] en_arr [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [RW-1:0] en_q;
    logic [RW-1:0] nxt_w;

    // software value first, then hardware clear masks it (clear wins)
    always_comb begin
      nxt_w = en_q;
      if (wr_en && wr_sel == SELW'(r)) nxt_w = wr_data;
      nxt_w = nxt_w & ~hw_clr[r*RW +: RW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (standby) en_q <= '0;
      else              en_q <= nxt_w;
    end

    assign en_arr[r] = en_q;
    assign en_flat[r*RW +: RW] = en_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_sel == SELW'(i)) rd_data = en_arr[i];
  end
endmodule

// File: rtl/dtc_xfer_cnt.sv
module dtc_xfer_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] cnt_q,
  output logic         last
);
  // wraps modulo 2**W, so a stored zero counts as the full range
  function automatic logic [W-1:0] f_dec(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  function automatic logic f_is_last(input logic [W-1:0] v);
    return v == W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (dec) cnt_q <= f_dec(cnt_q);
  end

  assign last = f_is_last(cnt_q);
endmodule

// File: rtl/dtc_act_seq.sv
module dtc_act_seq
  import dtc_act_pkg::*;
#(
  parameter int NSRC = 56,
  localparam int SRCW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [SRCW-1:0] req_src,
  input  logic [NSRC-1:0] en_flat,
  input  logic            xfer_done,
  input  logic            dis_sel,
  input  logic            cnt_last,
  output logic            busy,
  output logic            act_start,
  output logic [SRCW-1:0] act_src,
  output logic            cpu_req,
  output logic [SRCW-1:0] cpu_req_src,
  output logic            start_fire,
  output logic            done_fire,
  output logic [NSRC-1:0] hw_clr,
  output logic            end_irq,
  output logic [SRCW-1:0] end_src
);
  seq_st_e         st_q;
  logic [SRCW-1:0] served_q;
  logic            src_en;
  logic            clr_now;

  assign src_en      = (32'(req_src) < NSRC) ? en_flat[req_src] : 1'b0;
  assign start_fire  = req_valid && src_en && (st_q == SEQ_IDLE);
  assign cpu_req     = req_valid && !src_en;
  assign cpu_req_src = req_src;
  assign done_fire   = xfer_done && (st_q == SEQ_BUSY);
  assign clr_now     = done_fire && (dis_sel || cnt_last);

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      hw_clr[i] = clr_now && (served_q == SRCW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      served_q  <= '0;
      act_start <= 1'b0;
      end_irq   <= 1'b0;
      end_src   <= '0;
    end else begin
      act_start <= start_fire;
      end_irq   <= clr_now;
      if (clr_now) end_src <= served_q;
      if (start_fire) begin
        st_q     <= SEQ_BUSY;
        served_q <= req_src;
      end else if (done_fire) begin
        st_q <= SEQ_IDLE;
      end
    end
  end

  assign busy    = (st_q == SEQ_BUSY);
  assign act_src = served_q;
endmodule

// File: rtl/dtc_act_top.sv
module dtc_act_top #(
  parameter int NREG  = 7,
  parameter int RW    = 8,
  parameter int CNT_W = 16,
  localparam int NSRC = NREG * RW,
  localparam int SRCW = $clog2(NSRC),
  localparam int SELW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             wr_en,
  input  logic [SELW-1:0]  wr_sel,
  input  logic [RW-1:0]    wr_data,
  input  logic [SELW-1:0]  rd_sel,
  output logic [RW-1:0]    rd_data,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_ld_val,
  output logic [CNT_W-1:0] cnt_q,
  input  logic             req_valid,
  input  logic [SRCW-1:0]  req_src,
  output logic             act_start,
  output logic [SRCW-1:0]  act_src,
  output logic             busy,
  input  logic             xfer_done,
  input  logic             dis_sel,
  output logic             cpu_req,
  output logic [SRCW-1:0]  cpu_req_src,
  output logic             end_irq,
  output logic [SRCW-1:0]  end_src
);
  logic [NSRC-1:0] en_flat;
  logic [NSRC-1:0] hw_clr;
  logic            start_fire;
  logic            done_fire;
  logic            cnt_last;

  dtc_en_bank #(.NREG(NREG), .RW(RW)) bank_i (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hw_clr(hw_clr), .rd_sel(rd_sel), .rd_data(rd_data),
    .en_flat(en_flat)
  );

  dtc_xfer_cnt #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_val(cnt_ld_val),
    .dec(done_fire), .cnt_q(cnt_q), .last(cnt_last)
  );

  dtc_act_seq #(.NSRC(NSRC)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .en_flat(en_flat), .xfer_done(xfer_done), .dis_sel(dis_sel),
    .cnt_last(cnt_last), .busy(busy), .act_start(act_start),
    .act_src(act_src), .cpu_req(cpu_req), .cpu_req_src(cpu_req_src),
    .start_fire(start_fire), .done_fire(done_fire), .hw_clr(hw_clr),
    .end_irq(end_irq), .end_src(end_src)
  );
endmodule

// File: rtl/dtc_act_chk.sv
module dtc_act_chk #(
  parameter int NSRC  = 56,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic             cnt_ld,
  input logic [CNT_W-1:0] cnt_q,
  input logic             busy,
  input logic             act_start,
  input logic             cpu_req,
  input logic             start_fire,
  input logic             done_fire,
  input logic [NSRC-1:0]  hw_clr,
  input logic [NSRC-1:0]  en_flat,
  input logic             end_irq
);
  p_act_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_start |=> !act_start);

  p_pass_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !start_fire);

  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_start |-> !$past(busy));

  p_cnt_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_fire && !cnt_ld) |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));

  p_clear_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hw_clr));

  p_clear_sticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_clr) |=> ((en_flat & $past(hw_clr)) == '0));

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_clr) |=> end_irq);

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> $past(|hw_clr));

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> en_flat == '0);
endmodule

bind dtc_act_top dtc_act_chk #(.NSRC(NSRC), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .standby(standby), .cnt_ld(cnt_ld),
  .cnt_q(cnt_q), .busy(busy), .act_start(act_start), .cpu_req(cpu_req),
  .start_fire(start_fire), .done_fire(done_fire), .hw_clr(hw_clr),
  .en_flat(en_flat), .end_irq(end_irq)
);

// File: tb/dtc_act_top_tb_top.sv
`timescale 1ns/1ps
module dtc_act_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic        cnt_ld = 1'b0;
  logic [15:0] cnt_ld_val = '0;
  logic [15:0] cnt_q;
  logic        req_valid = 1'b0;
  logic [5:0]  req_src = '0;
  logic        act_start;
  logic [5:0]  act_src;
  logic        busy;
  logic        xfer_done = 1'b0;
  logic        dis_sel = 1'b0;
  logic        cpu_req;
  logic [5:0]  cpu_req_src;
  logic        end_irq;
  logic [5:0]  end_src;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dtc_act_top dut_i (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .cnt_q(cnt_q),
    .req_valid(req_valid), .req_src(req_src), .act_start(act_start),
    .act_src(act_src), .busy(busy), .xfer_done(xfer_done), .dis_sel(dis_sel),
    .cpu_req(cpu_req), .cpu_req_src(cpu_req_src), .end_irq(end_irq),
    .end_src(end_src)
  );

  // {source, loaded count, disable-select}
  localparam logic [22:0] VEC [6] = '{
    {6'd3,  16'd5,   1'b0},
    {6'd10, 16'd1,   1'b0},
    {6'd17, 16'd9,   1'b1},
    {6'd55, 16'd0,   1'b0},
    {6'd40, 16'd2,   1'b1},
    {6'd0,  16'd1,   1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ld(input logic [15:0] v);
    cnt_ld = 1'b1; cnt_ld_val = v;
    step();
    cnt_ld = 1'b0;
  endtask

  task automatic request(input logic [5:0] s);
    req_valid = 1'b1; req_src = s;
    step();
    req_valid = 1'b0;
  endtask

  task automatic finish_xfer(input logic d);
    xfer_done = 1'b1; dis_sel = d;
    step();
    xfer_done = 1'b0; dis_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd_sel = 3'(i); #0.1;
      chk("R1 reset reg", 32'(rd_data), 32'h0);
    end
    chk("R3 idle act_start", 32'(act_start), 0);
    chk("R5 idle busy", 32'(busy), 0);
    chk("R10 idle end_irq", 32'(end_irq), 0);

    // R2 read/write and unused index
    wr(3'd4, 8'hA5);
    rd_sel = 3'd4; #0.1;
    chk("R2 readback", 32'(rd_data), 32'hA5);
    rd_sel = 3'd7; #0.1;
    chk("R2 index 7 reads zero", 32'(rd_data), 32'h0);
    wr(3'd4, 8'h00);

    // R12 counter load
    ld(16'h1234);
    chk("R12 load", 32'(cnt_q), 32'h1234);

    // R6 done while idle ignored
    finish_xfer(1'b1);
    chk("R6 idle done keeps count", 32'(cnt_q), 32'h1234);
    chk("R10 idle done no irq", 32'(end_irq), 0);

    // vector table walk: R3 R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      logic [5:0]  s;
      logic [15:0] c;
      logic        d;
      logic        exp_clr;
      {s, c, d} = VEC[v];
      exp_clr = d || (c == 16'd1);
      wr(3'(s >> 3), 8'(1 << s[2:0]));
      ld(c);
      request(s);
      chk("R3 act_start", 32'(act_start), 1);
      chk("R3 act_src", 32'(act_src), 32'(s));
      chk("R3 busy", 32'(busy), 1);
      finish_xfer(d);
      rd_sel = 3'(s >> 3); #0.1;
      chk("R6 decrement", 32'(cnt_q), 32'(16'(c + 16'hFFFF)));
      chk("R7 R8 R9 enable after end", 32'(rd_data[s[2:0]]), 32'(!exp_clr));
      chk("R10 end_irq", 32'(end_irq), 32'(exp_clr));
      if (exp_clr) chk("R10 end_src", 32'(end_src), 32'(s));
      chk("R6 busy cleared", 32'(busy), 0);
      step();
      chk("R10 end_irq one cycle", 32'(end_irq), 0);
    end

    // R4 disabled source passes to CPU
    wr(3'd2, 8'h00);
    req_valid = 1'b1; req_src = 6'd20; #0.1;
    chk("R4 cpu_req", 32'(cpu_req), 1);
    chk("R4 cpu_req_src", 32'(cpu_req_src), 20);
    step();
    req_valid = 1'b0;
    chk("R4 no act_start", 32'(act_start), 0);
    chk("R4 not busy", 32'(busy), 0);

    // R5 no activation while busy
    wr(3'd0, 8'h30);
    ld(16'd100);
    request(6'd4);
    chk("R5 first start", 32'(act_start), 1);
    request(6'd5);
    chk("R5 no second start", 32'(act_start), 0);
    chk("R5 act_src held", 32'(act_src), 4);
    chk("R5 still busy", 32'(busy), 1);
    finish_xfer(1'b0);

    // R11 hardware clear vs software write, same register
    wr(3'd1, 8'h03);
    ld(16'd1);
    request(6'd9);
    xfer_done = 1'b1; dis_sel = 1'b0;
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'hF2;
    step();
    xfer_done = 1'b0; wr_en = 1'b0;
    rd_sel = 3'd1; #0.1;
    chk("R11 clear beats write", 32'(rd_data), 32'hF0);
    chk("R8 irq on collision", 32'(end_irq), 1);

    // R1 standby clears everything
    wr(3'd3, 8'hFF);
    wr(3'd6, 8'h81);
    standby = 1'b1;
    step();
    standby = 1'b0;
    for (int i = 0; i < 7; i++) begin
      rd_sel = 3'(i); #0.1;
      chk("R1 standby reg", 32'(rd_data), 32'h0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule